// File: doc/BRIEF.md
# Single-Bit Logic Unit with Carry Collector

This block is the Boolean datapath of a ladder-style instruction-list controller. It holds a one-bit working accumulator, a one-bit carry collector and an index register. It runs bit-level operations against an external bit memory through a synchronous read/write port. An operation arrives as an opcode, an index flag and an operand, qualified by a valid strobe. Operations that read memory take two cycles. `busy_o` is high during the second cycle, and no new operation is taken while it is high.

The carry collector turns a sum-of-products rung into straight-line code. Each product term is built in the accumulator. A collecting AND then folds the finished term into the carry register. A carry store writes the collected result to memory and clears the collector, so no temporary memory bits are needed. Any memory reference can be indexed. Its effective address is then the operand plus the index register, wrapped to the memory depth.

Top module: `bit_logic_unit`

## Requirements
- R1: After `rst_ni` is released, `acc_o`, `car_o` and `ix_o` are 0, `busy_o` is low, and neither `mem_rd_o` nor `mem_we_o` is asserted.
- R2: Opcode 2 (load) sets the accumulator to the addressed bit. Opcode 3 (load inverted) sets it to the complement of that bit. `mem_rd_o` is high in the accept cycle, `busy_o` is high in the following cycle, and the new accumulator value is visible after the second clock edge.
- R3: Opcode 4 (store) writes the accumulator to the addressed bit in the accept cycle. Opcode 5 (store inverted) writes its complement. A read and a write are never issued together.
- R4: Opcode 6 (set) writes 1 and opcode 7 (reset) writes 0 to the addressed bit, but only when the accumulator is 1. When the accumulator is 0 the memory is left unchanged.
- R5: Opcode 8 (collecting AND) sets the accumulator to accumulator AND addressed bit, then sets the carry to carry OR the new accumulator value. Both are visible after the second clock edge.
- R6: Opcode 9 (carry store) writes the carry to the addressed bit and opcode 10 (carry store inverted) writes its complement. Either one clears the carry to 0 at the same edge.
- R7: Opcode 1 (load index) loads the index register from the operand. It is visible on `ix_o` after the accept edge.
- R8: When `idx_i` is 1, the effective address is `(operand_i + ix_o) mod DEPTH`, for reads and for writes alike.
- R9: While `busy_o` is high, `op_valid_i` is ignored. No memory strobe is issued and no register changes because of it.
- R10: Opcode 0 and opcodes 11 to 15 change no register and issue no memory strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| idx_i | input | 1 | Indexed addressing select |
| operand_i | input | AW | Bit address, or immediate value for load index |
| busy_o | output | 1 | Read completion in progress; new operations are ignored |
| acc_o | output | 1 | Accumulator |
| car_o | output | 1 | Carry collector |
| ix_o | output | AW | Index register |
| mem_addr_o | output | AW | Bit memory address |
| mem_rd_o | output | 1 | Read enable; data is expected on `mem_rdata_i` the next cycle |
| mem_rdata_i | input | 1 | Read data |
| mem_we_o | output | 1 | Write enable |
| mem_wdata_o | output | 1 | Write data |

## Verification
The hardest case to reach from the ports is an operation offered while a read is still completing. The stimulus has to present a fresh strobe exactly in the one cycle that `busy_o` is high. To get there, the bench issues a load and then drives a store on the very next cycle, aimed at a bit whose value the store would flip. It then checks that no write strobe appears, that the bit is untouched and that the load still lands. Indexed wrap-around is reached by loading the index register with a value close to the memory depth, so that the sum overflows the address width.

// File: rtl/blu_pkg.sv
package blu_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LDX  = 4'd1,
    OP_LD   = 4'd2,
    OP_LDN  = 4'd3,
    OP_ST   = 4'd4,
    OP_STN  = 4'd5,
    OP_SET  = 4'd6,
    OP_RST  = 4'd7,
    OP_CAND = 4'd8,
    OP_CST  = 4'd9,
    OP_CSTN = 4'd10
  } blu_op_e;

  function automatic logic op_reads(input logic [3:0] op);
    return op == OP_LD || op == OP_LDN || op == OP_CAND;
  endfunction
endpackage

// File: rtl/blu_addr_gen.sv
module blu_addr_gen #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] operand_i,
  input  logic [AW-1:0] ix_i,
  input  logic          idx_i,
  output logic [AW-1:0] ea_o
);
  // sum truncated to AW bits: wraps modulo the power-of-two depth
  always_comb ea_o = idx_i ? operand_i + ix_i : operand_i;
endmodule

// File: rtl/blu_seq.sv
module blu_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic [3:0] op_i,
  output logic       busy_o,
  output logic [3:0] pend_op_o
);
  logic       busy_q;
  logic [3:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= blu_pkg::OP_NOP;
    end else begin
      busy_q <= accept_i && blu_pkg::op_reads(op_i);
      if (accept_i) pend_q <= op_i;
    end
  end

  assign busy_o    = busy_q;
  assign pend_op_o = pend_q;

  a_r2_read_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && blu_pkg::op_reads(op_i)) |=> busy_q);
  a_r9_busy_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q);
endmodule

// File: rtl/blu_bitregs.sv
module blu_bitregs #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] operand_i,
  input  logic          done_i,
  input  logic [3:0]    pend_op_i,
  input  logic          rdata_i,
  output logic          acc_o,
  output logic          car_o,
  output logic [AW-1:0] ix_o
);
  import blu_pkg::*;

  logic          acc_q, car_q;
  logic [AW-1:0] ix_q;
  logic          prod;

  assign prod = acc_q & rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      car_q <= 1'b0;
      ix_q  <= '0;
    end else if (accept_i) begin
      case (op_i)
        OP_LDX:          ix_q  <= operand_i;
        OP_CST, OP_CSTN: car_q <= 1'b0;
        default: ;
      endcase
    end else if (done_i) begin
      case (pend_op_i)
        OP_LD:   acc_q <= rdata_i;
        OP_LDN:  acc_q <= ~rdata_i;
        OP_CAND: begin
          acc_q <= prod;
          car_q <= car_q | prod;
        end
        default: ;
      endcase
    end
  end

  assign acc_o = acc_q;
  assign car_o = car_q;
  assign ix_o  = ix_q;

  a_r6_carry_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && (op_i == OP_CST || op_i == OP_CSTN)) |=> !car_q);
  a_r5_carry_rises_on_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(car_q) |-> $past(done_i && pend_op_i == OP_CAND));
  a_r7_ix_only_on_ldx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_i && op_i == OP_LDX) |=> $stable(ix_q));
endmodule

// File: rtl/bit_logic_unit.sv
module bit_logic_unit #(
  parameter int REGS     = 8,
  parameter int REG_BITS = 8,
  localparam int DEPTH   = REGS * REG_BITS,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [3:0]    op_i,
  input  logic          idx_i,
  input  logic [AW-1:0] operand_i,
  output logic          busy_o,
  output logic          acc_o,
  output logic          car_o,
  output logic [AW-1:0] ix_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic          mem_rdata_i,
  output logic          mem_we_o,
  output logic          mem_wdata_o
);
  import blu_pkg::*;

  logic       accept;
  logic [3:0] pend_op;

  assign accept = op_valid_i && !busy_o;

  blu_addr_gen #(.AW(AW)) u_addr (
    .operand_i(operand_i), .ix_i(ix_o), .idx_i(idx_i), .ea_o(mem_addr_o)
  );

  blu_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .op_i(op_i),
    .busy_o(busy_o), .pend_op_o(pend_op)
  );

  blu_bitregs #(.AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .op_i(op_i),
    .operand_i(operand_i), .done_i(busy_o), .pend_op_i(pend_op),
    .rdata_i(mem_rdata_i), .acc_o(acc_o), .car_o(car_o), .ix_o(ix_o)
  );

  always_comb begin
    mem_we_o    = 1'b0;
    mem_wdata_o = 1'b0;
    mem_rd_o    = accept && op_reads(op_i);
    if (accept) begin
      case (op_i)
        OP_ST:   begin mem_we_o = 1'b1;  mem_wdata_o = acc_o;  end
        OP_STN:  begin mem_we_o = 1'b1;  mem_wdata_o = ~acc_o; end
        OP_SET:  begin mem_we_o = acc_o; mem_wdata_o = 1'b1;   end
        OP_RST:  begin mem_we_o = acc_o; mem_wdata_o = 1'b0;   end
        OP_CST:  begin mem_we_o = 1'b1;  mem_wdata_o = car_o;  end
        OP_CSTN: begin mem_we_o = 1'b1;  mem_wdata_o = ~car_o; end
        default: ;
      endcase
    end
  end

  a_r9_no_strobe_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mem_we_o && !mem_rd_o);
  a_r3_rd_we_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_rd_o));
  a_r4_no_write_acc_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_i == OP_SET || op_i == OP_RST) && !acc_o) |-> !mem_we_o);
  a_r10_unused_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_i == OP_NOP || op_i > OP_CSTN)) |-> !mem_we_o && !mem_rd_o);
endmodule

// File: tb/bit_logic_unit_bench.sv
module bit_logic_unit_bench;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          op_valid = 1'b0;
  logic [3:0]    op = 4'd0;
  logic          idx = 1'b0;
  logic [AW-1:0] operand = '0;
  logic          busy, acc, car;
  logic [AW-1:0] ix, mem_addr;
  logic          mem_rd, mem_we, mem_wdata;
  logic          mem_rdata;
  logic          mem [DEPTH];
  int            n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bit_logic_unit u_bit_logic_unit (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid), .op_i(op),
    .idx_i(idx), .operand_i(operand), .busy_o(busy), .acc_o(acc),
    .car_o(car), .ix_o(ix), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, return at a negedge once the result is visible
  task automatic issue(input logic [3:0] o, input logic ix_sel, input int a);
    @(negedge clk);
    op_valid = 1'b1; op = o; idx = ix_sel; operand = AW'(a);
    @(negedge clk);
    op_valid = 1'b0;
    if (o == 4'd2 || o == 4'd3 || o == 4'd8) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 acc", int'(acc), 0);
    chk("R1 car", int'(car), 0);
    chk("R1 ix", int'(ix), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 strobes", int'(mem_rd | mem_we), 0);
  endtask

  task automatic t_load;
    @(negedge clk);
    op_valid = 1'b1; op = 4'd2; idx = 1'b0; operand = 6'd3;
    #1 chk("R2 rd strobe", int'(mem_rd), 1);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R2 busy", int'(busy), 1);
    @(negedge clk);
    chk("R2 ld 1", int'(acc), 1);
    chk("R2 busy clear", int'(busy), 0);
    issue(4'd3, 1'b0, 3); chk("R2 ldn 1", int'(acc), 0);
    issue(4'd2, 1'b0, 4); chk("R2 ld 0", int'(acc), 0);
    issue(4'd3, 1'b0, 4); chk("R2 ldn 0", int'(acc), 1);
  endtask

  task automatic t_store;
    issue(4'd4, 1'b0, 10); chk("R3 st", int'(mem[10]), 1);
    issue(4'd5, 1'b0, 12); chk("R3 stn", int'(mem[12]), 0);
  endtask

  task automatic t_setrst;
    issue(4'd6, 1'b0, 20); chk("R4 set acc1", int'(mem[20]), 1);
    issue(4'd2, 1'b0, 4);
    issue(4'd6, 1'b0, 22); chk("R4 set acc0", int'(mem[22]), 0);
    issue(4'd7, 1'b0, 21); chk("R4 rst acc0", int'(mem[21]), 1);
    issue(4'd2, 1'b0, 3);
    issue(4'd7, 1'b0, 21); chk("R4 rst acc1", int'(mem[21]), 0);
  endtask

  task automatic t_cand;
    issue(4'd2, 1'b0, 3);
    issue(4'd8, 1'b0, 4);
    chk("R5 and 1.0 acc", int'(acc), 0);
    chk("R5 and 1.0 car", int'(car), 0);
    issue(4'd2, 1'b0, 3);
    issue(4'd8, 1'b0, 6);
    chk("R5 and 1.1 acc", int'(acc), 1);
    chk("R5 and 1.1 car", int'(car), 1);
    issue(4'd2, 1'b0, 4);
    issue(4'd8, 1'b0, 6);
    chk("R5 and 0.1 acc", int'(acc), 0);
    chk("R5 car holds", int'(car), 1);
  endtask

  task automatic t_carry;
    issue(4'd10, 1'b0, 41);
    chk("R6 cstn data", int'(mem[41]), 0);
    chk("R6 cstn clear", int'(car), 0);
    issue(4'd2, 1'b0, 3);
    issue(4'd8, 1'b0, 9);
    issue(4'd9, 1'b0, 43);
    chk("R6 cst data", int'(mem[43]), 1);
    chk("R6 cst clear", int'(car), 0);
  endtask

  task automatic t_index;
    issue(4'd1, 1'b0, 5); chk("R7 ldx", int'(ix), 5);
    issue(4'd2, 1'b1, 1); chk("R8 idx ld", int'(acc), 1);
    issue(4'd4, 1'b1, 3); chk("R8 idx st", int'(mem[8]), 1);
    issue(4'd1, 1'b0, 62); chk("R7 ldx 62", int'(ix), 62);
    issue(4'd4, 1'b1, 7); chk("R8 wrap st", int'(mem[5]), 1);
    issue(4'd3, 1'b1, 4); chk("R8 wrap ldn", int'(acc), 1);
  endtask

  task automatic t_busy;
    issue(4'd2, 1'b0, 3);
    @(negedge clk);
    op_valid = 1'b1; op = 4'd2; idx = 1'b0; operand = 6'd4;
    @(negedge clk);
    op = 4'd4; operand = 6'd50;
    #1 chk("R9 busy", int'(busy), 1);
    chk("R9 no we", int'(mem_we), 0);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9 mem kept", int'(mem[50]), 0);
    chk("R9 load done", int'(acc), 0);
  endtask

  task automatic t_unused;
    issue(4'd2, 1'b0, 3);
    issue(4'd2, 1'b0, 3);
    issue(4'd8, 1'b0, 6);
    for (int c = 11; c < 16; c++) begin
      @(negedge clk);
      op_valid = 1'b1; op = 4'(c); idx = 1'b0; operand = 6'd13;
      #1 chk("R10 no strobe", int'(mem_we | mem_rd), 0);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R10 regs", int'({acc, car, ix}), int'({1'b1, 1'b1, 6'd62}));
    end
    issue(4'd0, 1'b0, 13);
    chk("R10 nop regs", int'({acc, car, busy}), int'({1'b1, 1'b1, 1'b0}));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = (i % 3 == 0);
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_reset;
    t_load;
    t_store;
    t_setrst;
    t_cand;
    t_carry;
    t_index;
    t_busy;
    t_unused;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule